// File: doc/BRIEF.md
# Transmit Interface Protocol Checker

This block sits beside a wide transmit user interface and watches every beat as it goes past. Each beat carries up to eight 8-byte words. Two 2-bit markers say where a packet and where a burst begin: at the first word, at the middle word, or not at all. An end marker closes the current burst. The block never touches the data. Its only job is to notice traffic that the downstream packetizer cannot handle and to report it as a one-cycle error pulse.

Three rules are enforced:
- A start marker must not carry its reserved code.
- Two packet starts, or two burst starts, must be at least 64 bytes apart.
- In interleaved mode, a burst must not grow beyond a byte limit supplied on an input.

Packet starts and burst starts are tracked separately. A beat whose valid is low is invisible to every check.

Top module: `tx_rule_checker`

## Requirements
- R1: A synchronous active-high reset clears every counter and holds the error output low. The first packet start and the first burst start after reset are never reported as too close.
- R2: A valid beat whose packet marker or burst marker equals 2'b11 produces an error pulse. The marker codes are: 2'b00 no start, 2'b10 start at word 0, 2'b01 start at word 4. A 2'b11 marker is not treated as a start.
- R3: A valid packet start that is fewer than 64 bytes after the previous packet start produces an error pulse. The distance is the sum of three parts: the valid bytes from the previous start to the end of its beat, the valid bytes (8 per counted word) of each valid beat in between, and the bytes before the new start in its own beat (0 or 32). A distance of exactly 64 is legal.
- R4: Burst starts are spaced by the same rule as R3, with a tracker of their own. A packet start never affects burst spacing, and a burst start never affects packet spacing.
- R5: In interleaved mode (`interleaved` = 1), a burst is measured from its start position to the end of its start beat, plus 8 bytes per word of each later valid beat. It produces exactly one error pulse, on the beat where it first exceeds `maxBurst` bytes. A burst of exactly `maxBurst` bytes is legal. No further pulse follows until the next burst start.
- R6: In packet mode (`interleaved` = 0), burst length never produces an error pulse.
- R7: A valid beat with `beatEnd` = 1 closes the open burst after its own bytes are counted. Valid beats without a burst start that follow a closed burst add nothing to any burst length.
- R8: A beat with `beatValid` = 0 produces no error pulse and changes no counter, whatever its markers or word count.
- R9: Several violations on the same beat produce a single error pulse one cycle wide.
- R10: The error pulse is high for exactly the one clock cycle after the edge that samples the violating beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beatValid | input | 1 | Beat carries data |
| sopMark | input | 2 | Packet start marker (00 none, 10 word 0, 01 word 4, 11 reserved) |
| sobMark | input | 2 | Burst start marker, same coding as sopMark |
| beatEnd | input | 1 | Beat ends the current burst |
| wordCount | input | 4 | Number of valid 8-byte words in the beat (0 to 8; larger values count as 8) |
| interleaved | input | 1 | 1 enables the burst length limit |
| maxBurst | input | 16 | Burst length limit in bytes, a multiple of 64 |
| errPulse | output | 1 | One-cycle protocol error pulse |

## Verification
The bench builds the block with its default parameters: eight words of eight bytes per beat, a 64-byte minimum spacing, and a 16-bit burst length. With these values, a start at word 4 followed by a start at word 0 lands at 32 bytes, and a start at word 4 followed by another at word 4 lands at exactly 64 bytes, so both sides of the spacing boundary can be reached in two beats. The bench drives `maxBurst` at 64 and 128, so a burst reaches its limit after one or two beats. That keeps the exact-limit case, the first-overrun case, the overrun after a word-4 start and the effect of the end marker all short enough to check beat by beat.

// File: rtl/tx_chk_pkg.sv
package tx_chk_pkg;

  typedef enum logic [1:0] {
    MK_NONE = 2'b00,
    MK_HALF = 2'b01,
    MK_FULL = 2'b10,
    MK_BAD  = 2'b11
  } mark_e;

  typedef struct packed {
    logic take;      // beat is valid
    logic sopStart;  // legal packet start
    logic sopHalf;   // packet start at the middle word
    logic sobStart;  // legal burst start
    logic sobHalf;   // burst start at the middle word
    logic closeBurst;
  } strobes_t;

  typedef struct packed {
    logic sopClose;
    logic sobClose;
    logic burstLong;
  } hits_t;

endpackage

// File: rtl/tx_chk_gap.sv
module tx_chk_gap #(
  parameter int GAP_BYTES = 64,
  parameter int SUM_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             isStart,
  input  logic [SUM_W-1:0] leadBytes,
  input  logic [SUM_W-1:0] tailBytes,
  input  logic [SUM_W-1:0] beatBytes,
  output logic             tooClose
);

  localparam logic [SUM_W-1:0] GAP = SUM_W'(GAP_BYTES);

  logic             seen;
  logic [SUM_W-1:0] sinceStart;
  logic [SUM_W-1:0] distance;
  logic [SUM_W-1:0] grown;

  always_comb begin
    distance = sinceStart + leadBytes;
    grown    = sinceStart + beatBytes;
    tooClose = take && isStart && seen && (distance < GAP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen       <= 1'b0;
      sinceStart <= '0;
    end else if (take) begin
      if (isStart) begin
        seen       <= 1'b1;
        sinceStart <= (tailBytes > GAP) ? GAP : tailBytes;
      end else begin
        sinceStart <= (grown > GAP) ? GAP : grown;
      end
    end
  end

endmodule

// File: rtl/tx_chk_datapath.sv
module tx_chk_datapath
  import tx_chk_pkg::*;
#(
  parameter int WORDS      = 8,
  parameter int WORD_BYTES = 8,
  parameter int GAP_BYTES  = 64,
  parameter int BURST_W    = 16,
  parameter int WC_W       = $clog2(WORDS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  strobes_t           strb,
  input  logic [WC_W-1:0]    words,
  input  logic               interleaved,
  input  logic [BURST_W-1:0] maxBurst,
  output hits_t              hits
);

  localparam int BEAT_BYTES = WORDS * WORD_BYTES;
  localparam int HALF_BYTES = (WORDS / 2) * WORD_BYTES;
  localparam int SUM_W      = $clog2(GAP_BYTES + BEAT_BYTES + 1);
  localparam int NTRACK     = 2;

  logic [SUM_W-1:0] beatBytes;
  logic [SUM_W-1:0] leadBytes [NTRACK];
  logic [SUM_W-1:0] tailBytes [NTRACK];
  logic             isStart   [NTRACK];
  logic             isHalf    [NTRACK];
  logic             closeHit  [NTRACK];

  always_comb begin
    beatBytes  = SUM_W'(words) * SUM_W'(WORD_BYTES);
    isStart[0] = strb.sopStart;
    isHalf[0]  = strb.sopHalf;
    isStart[1] = strb.sobStart;
    isHalf[1]  = strb.sobHalf;
  end

  for (genvar g = 0; g < NTRACK; g++) begin : gTrack
    always_comb begin
      leadBytes[g] = isHalf[g] ? SUM_W'(HALF_BYTES) : '0;
      tailBytes[g] = (beatBytes > leadBytes[g]) ? beatBytes - leadBytes[g] : '0;
    end

    tx_chk_gap #(
      .GAP_BYTES(GAP_BYTES),
      .SUM_W    (SUM_W)
    ) uGap (
      .clk      (clk),
      .rst      (rst),
      .take     (strb.take),
      .isStart  (isStart[g]),
      .leadBytes(leadBytes[g]),
      .tailBytes(tailBytes[g]),
      .beatBytes(beatBytes),
      .tooClose (closeHit[g])
    );
  end

  // Burst length meter
  logic               burstOpen;
  logic               overSeen;
  logic [BURST_W-1:0] burstCnt;
  logic [BURST_W:0]   baseLen;
  logic [BURST_W:0]   addLen;
  logic [BURST_W:0]   newTotal;
  logic               counting;
  logic               overNow;

  always_comb begin
    counting = strb.take && (strb.sobStart || burstOpen);
    baseLen  = strb.sobStart ? '0 : {1'b0, burstCnt};
    addLen   = strb.sobStart ? (BURST_W + 1)'(tailBytes[1]) : (BURST_W + 1)'(beatBytes);
    newTotal = baseLen + addLen;
    overNow  = counting && interleaved && (newTotal > {1'b0, maxBurst})
               && (strb.sobStart || !overSeen);
    hits.sopClose  = closeHit[0];
    hits.sobClose  = closeHit[1];
    hits.burstLong = overNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burstOpen <= 1'b0;
      overSeen  <= 1'b0;
      burstCnt  <= '0;
    end else if (counting) begin
      burstCnt  <= newTotal[BURST_W] ? '1 : newTotal[BURST_W-1:0];
      burstOpen <= !strb.closeBurst;
      overSeen  <= (strb.sobStart ? 1'b0 : overSeen) | overNow;
    end
  end

endmodule

// File: rtl/tx_chk_control.sv
module tx_chk_control
  import tx_chk_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WC_W  = $clog2(WORDS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            beatValid,
  input  logic [1:0]      sopMark,
  input  logic [1:0]      sobMark,
  input  logic            beatEnd,
  input  logic [WC_W-1:0] wordCount,
  input  hits_t           hits,
  output strobes_t        strb,
  output logic [WC_W-1:0] words,
  output logic            errPulse
);

  logic badCode;
  logic anyHit;

  always_comb begin
    strb.take       = beatValid;
    strb.sopStart   = beatValid && (sopMark == MK_FULL || sopMark == MK_HALF);
    strb.sopHalf    = sopMark == MK_HALF;
    strb.sobStart   = beatValid && (sobMark == MK_FULL || sobMark == MK_HALF);
    strb.sobHalf    = sobMark == MK_HALF;
    strb.closeBurst = beatValid && beatEnd;
    words   = (wordCount > WC_W'(WORDS)) ? WC_W'(WORDS) : wordCount;
    badCode = beatValid && (sopMark == MK_BAD || sobMark == MK_BAD);
    anyHit  = badCode || hits.sopClose || hits.sobClose || hits.burstLong;
  end

  always_ff @(posedge clk) begin
    if (rst) errPulse <= 1'b0;
    else     errPulse <= anyHit;
  end

endmodule

// File: rtl/tx_rule_checker.sv
module tx_rule_checker
  import tx_chk_pkg::*;
#(
  parameter int WORDS      = 8,
  parameter int WORD_BYTES = 8,
  parameter int GAP_BYTES  = 64,
  parameter int BURST_W    = 16,
  parameter int WC_W       = $clog2(WORDS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               beatValid,
  input  logic [1:0]         sopMark,
  input  logic [1:0]         sobMark,
  input  logic               beatEnd,
  input  logic [WC_W-1:0]    wordCount,
  input  logic               interleaved,
  input  logic [BURST_W-1:0] maxBurst,
  output logic               errPulse
);

  strobes_t        strb;
  hits_t           hits;
  logic [WC_W-1:0] words;

  tx_chk_control #(.WORDS(WORDS), .WC_W(WC_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .beatValid(beatValid),
    .sopMark  (sopMark),
    .sobMark  (sobMark),
    .beatEnd  (beatEnd),
    .wordCount(wordCount),
    .hits     (hits),
    .strb     (strb),
    .words    (words),
    .errPulse (errPulse)
  );

  tx_chk_datapath #(
    .WORDS     (WORDS),
    .WORD_BYTES(WORD_BYTES),
    .GAP_BYTES (GAP_BYTES),
    .BURST_W   (BURST_W),
    .WC_W      (WC_W)
  ) uData (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .words      (words),
    .interleaved(interleaved),
    .maxBurst   (maxBurst),
    .hits       (hits)
  );

endmodule

// File: rtl/tx_rule_checker_props.sv
module tx_rule_checker_props (
  input logic       clk,
  input logic       rst,
  input logic       beatValid,
  input logic [1:0] sopMark,
  input logic [1:0] sobMark,
  input logic       errPulse
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !errPulse); // R1

  AST_BAD_CODE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    beatValid && (sopMark == 2'b11 || sobMark == 2'b11) |=> errPulse); // R2

  AST_SOP_HALF_THEN_FULL: assert property (@(posedge clk) disable iff (rst)
    beatValid && sopMark == 2'b10 && !$past(rst)
    && $past(beatValid && sopMark == 2'b01) |=> errPulse); // R3

  AST_SOB_HALF_THEN_FULL: assert property (@(posedge clk) disable iff (rst)
    beatValid && sobMark == 2'b10 && !$past(rst)
    && $past(beatValid && sobMark == 2'b01) |=> errPulse); // R4

  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    !beatValid |=> !errPulse); // R8

endmodule

bind tx_rule_checker tx_rule_checker_props uProps (
  .clk      (clk),
  .rst      (rst),
  .beatValid(beatValid),
  .sopMark  (sopMark),
  .sobMark  (sobMark),
  .errPulse (errPulse)
);

// File: tb/tb_tx_rule_checker.sv
module tb_tx_rule_checker;

  logic        clk = 1'b0;
  logic        rst;
  logic        beatValid;
  logic [1:0]  sopMark;
  logic [1:0]  sobMark;
  logic        beatEnd;
  logic [3:0]  wordCount;
  logic        interleaved;
  logic [15:0] maxBurst;
  logic        errPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tx_rule_checker dut (
    .clk        (clk),
    .rst        (rst),
    .beatValid  (beatValid),
    .sopMark    (sopMark),
    .sobMark    (sobMark),
    .beatEnd    (beatEnd),
    .wordCount  (wordCount),
    .interleaved(interleaved),
    .maxBurst   (maxBurst),
    .errPulse   (errPulse)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: errPulse=%b expected %b", req, got, exp);
    end
  endtask

  // Drive one beat at a falling edge; errPulse is read at the next falling edge.
  task automatic beat(input string req, input logic v, input logic [1:0] sop,
                      input logic [1:0] sob, input logic e, input logic [3:0] wc,
                      input logic exp);
    beatValid = v; sopMark = sop; sobMark = sob; beatEnd = e; wordCount = wc;
    @(negedge clk);
    check(req, errPulse, exp);
  endtask

  task automatic doReset(input logic mode, input logic [15:0] limit);
    rst = 1'b1; beatValid = 1'b0; sopMark = 2'b00; sobMark = 2'b00;
    beatEnd = 1'b0; wordCount = 4'd0; interleaved = mode; maxBurst = limit;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testReset;
    doReset(1'b0, 16'd1024);
    beatValid = 1'b1; sopMark = 2'b01; sobMark = 2'b01; wordCount = 4'd8;
    @(negedge clk);
    doReset(1'b0, 16'd1024);
    check("R1 reset state", errPulse, 1'b0);
    beat("R1 first starts after reset", 1, 2'b10, 2'b10, 0, 8, 1'b0);
  endtask

  task automatic testBadCode;
    doReset(1'b0, 16'd1024);
    beat("R2 packet marker 11", 1, 2'b11, 2'b00, 0, 8, 1'b1);
    beat("R10 pulse one cycle wide", 0, 2'b00, 2'b00, 0, 0, 1'b0);
    beat("R2 burst marker 11", 1, 2'b00, 2'b11, 0, 8, 1'b1);
  endtask

  task automatic testSopGap;
    doReset(1'b0, 16'd1024);
    beat("R3 first packet start", 1, 2'b01, 2'b00, 0, 8, 1'b0);
    beat("R3 32-byte spacing", 1, 2'b10, 2'b00, 0, 8, 1'b1);
    beat("R3 96-byte spacing", 1, 2'b01, 2'b00, 0, 8, 1'b0);
    beat("R3 filler beat", 1, 2'b00, 2'b00, 0, 8, 1'b0);
    beat("R3 saturated spacing", 1, 2'b10, 2'b00, 0, 4, 1'b0);
    beat("R3 exactly 64 bytes", 1, 2'b01, 2'b00, 0, 8, 1'b0);
    beat("R3 short after word-4 start", 1, 2'b10, 2'b00, 0, 3, 1'b1);
  endtask

  task automatic testSobGap;
    doReset(1'b0, 16'd1024);
    beat("R4 packet start only", 1, 2'b01, 2'b00, 0, 8, 1'b0);
    beat("R4 first burst start", 1, 2'b00, 2'b10, 0, 8, 1'b0);
    beat("R4 64-byte burst spacing", 1, 2'b00, 2'b10, 0, 8, 1'b0);
    beat("R4 96-byte burst spacing", 1, 2'b00, 2'b01, 0, 8, 1'b0);
    beat("R4 32-byte burst spacing", 1, 2'b00, 2'b10, 0, 8, 1'b1);
  endtask

  task automatic testBurstLimit;
    doReset(1'b1, 16'd128);
    beat("R5 burst 64", 1, 2'b00, 2'b10, 0, 8, 1'b0);
    beat("R5 burst exactly limit", 1, 2'b00, 2'b00, 0, 8, 1'b0);
    beat("R5 burst over limit", 1, 2'b00, 2'b00, 0, 2, 1'b1);
    beat("R5 no second pulse", 1, 2'b00, 2'b00, 0, 8, 1'b0);
    beat("R5 new burst", 1, 2'b00, 2'b10, 0, 8, 1'b0);
    beat("R5 new burst at limit", 1, 2'b00, 2'b00, 0, 8, 1'b0);
    beat("R5 word-4 burst start", 1, 2'b00, 2'b01, 0, 8, 1'b0);
    beat("R5 word-4 burst 96", 1, 2'b00, 2'b00, 0, 8, 1'b0);
    beat("R5 word-4 burst 160", 1, 2'b00, 2'b00, 0, 8, 1'b1);
  endtask

  task automatic testPacketMode;
    doReset(1'b0, 16'd64);
    beat("R6 burst start", 1, 2'b00, 2'b10, 0, 8, 1'b0);
    for (int i = 0; i < 3; i++)
      beat("R6 long burst in packet mode", 1, 2'b00, 2'b00, 0, 8, 1'b0);
  endtask

  task automatic testBurstEnd;
    doReset(1'b1, 16'd128);
    beat("R7 burst start", 1, 2'b00, 2'b10, 0, 8, 1'b0);
    beat("R7 end beat at limit", 1, 2'b00, 2'b00, 1, 8, 1'b0);
    beat("R7 beat after end", 1, 2'b00, 2'b00, 0, 8, 1'b0);
    beat("R7 second beat after end", 1, 2'b00, 2'b00, 0, 8, 1'b0);
  endtask

  task automatic testIgnore;
    doReset(1'b1, 16'd64);
    beat("R8 packet start", 1, 2'b10, 2'b00, 0, 8, 1'b0);
    beat("R8 invalid bad codes", 0, 2'b11, 2'b11, 0, 8, 1'b0);
    beat("R8 invalid start", 0, 2'b10, 2'b10, 0, 8, 1'b0);
    beat("R8 word-4 start", 1, 2'b01, 2'b00, 0, 8, 1'b0);
    beat("R8 invalid data", 0, 2'b00, 2'b00, 0, 8, 1'b0);
    beat("R8 invalid data", 0, 2'b00, 2'b00, 0, 8, 1'b0);
    beat("R8 spacing ignores invalid beats", 1, 2'b10, 2'b00, 0, 8, 1'b1);
  endtask

  task automatic testMulti;
    doReset(1'b1, 16'd64);
    beat("R9 first starts", 1, 2'b01, 2'b10, 0, 8, 1'b0);
    beat("R9 three violations", 1, 2'b10, 2'b11, 0, 8, 1'b1);
    beat("R9 single pulse", 0, 2'b00, 2'b00, 0, 0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testBadCode();
    testSopGap();
    testSobGap();
    testBurstLimit();
    testPacketMode();
    testBurstEnd();
    testIgnore();
    testMulti();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule